// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is the countdown timer of a per-processor interrupt controller. A 32-bit counter is loaded by software and counts down on ticks made from the bus clock by a power-of-two prescaler. When the count is used up, the block raises a single-cycle request that carries the 8-bit vector held in its control word. The consumer hands that vector to the priority logic. The timer runs in one of two modes. In one-shot mode it expires once and then stays at zero. In periodic mode it reloads and keeps firing.

Software works through four word-wide registers, selected by a 2-bit address. Address 0 is the control word, address 1 the load value, address 2 the live count and address 3 the divider setting. Writing the load value restarts the count and the prescaler at once. A control-word write leaves the count alone and only changes how the next expiry is handled.

Top module: `local_irq_timer`

## Requirements
- R1: After reset the control word reads 0x0001_0000, the load value, live count and divider setting read 0, and `irq_pulse` is low.
- R2: The control word keeps the vector in bits [7:0], the mask in bit 16 and the periodic flag in bit 17. All other bits read as 0. Register addresses are: 0 control, 1 load value, 2 live count, 3 divider.
- R3: A divider write keeps only bits 0, 1 and 3. All other bits read back as 0.
- R4: The divider index is {bit3, bit1, bit0}. Ticks come every N = 2^((index+1) mod 8) clocks, so index 7 divides by 1 and indices 0..6 divide by 2..128.
- R5: A load-value write restarts the counter and the prescaler at that clock edge. The k-th tick after it is taken at the edge k*N clocks later, and the count changes only on ticks.
- R6: In one-shot mode the count steps down to 0. The tick after that expires the timer, and `irq_pulse` is high in the cycle after the edge (load+1)*N clocks past the load write. The count then holds at 0 and no further pulse comes.
- R7: In periodic mode the expiry tick reloads the load value, so pulses repeat every (load+1)*N clocks.
- R8: A load value of 0 produces no pulse in either mode, and the live count stays 0.
- R9: When the mask bit is set at expiry no pulse is raised. Counting and reloading go on unchanged.
- R10: `irq_pulse` lasts one cycle, and `irq_vector` then equals the control vector in force at the expiry.
- R11: Reading address 2 returns the live count with no side effect. A write to address 2 is ignored.
- R12: A control-word write does not move the counter or prescaler phase. A new mask or mode applies from the next expiry on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_pulse | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector of the last expiry |

## Verification
The hardest case to reach is a periodic timer whose mask is raised and later cleared while it keeps running. The later pulse must land on the original period grid, which shows that control writes never disturbed the count or the prescaler. The stimulus arms a periodic timer with a divide-by-4 prescaler and lets three pulses through. It then masks across two silent expiries, unmasks at an arbitrary cycle, and predicts the next grid point from the cycle of the unmask write. A zero load value then ends the sequence. A second hard case is a reload that arrives mid-count: the old expiry must vanish and a new one must appear relative to the rewrite edge.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;
   localparam int CTRL_MASK_BIT = 16;
   localparam int CTRL_PER_BIT  = 17;
   localparam int DIV_KEEP      = 32'h0000_000B;

   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_LOAD = 2'd1,
      RA_LIVE = 2'd2,
      RA_DIV  = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/irqtmr_prescaler.sv
module irqtmr_prescaler #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [IDX_W-1:0] div_idx,
   output logic             tick
);
   localparam int PRE_W = (1 << IDX_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [IDX_W-1:0] shift;
   logic [PRE_W-1:0] low_mask;

   // shift wraps modulo 2^IDX_W, so the top index selects divide-by-1
   assign shift = div_idx + IDX_W'(1);

   for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign low_mask[i] = (int'(shift) > i);
   end

   assign tick = &(pre_q | ~low_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (restart) pre_q <= '0;
      else              pre_q <= pre_q + PRE_W'(1);
   end
endmodule

// File: rtl/irqtmr_counter.sv
module irqtmr_counter #(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load_wr,
   input  logic [CNT_W-1:0] load_data,
   input  logic [CNT_W-1:0] load_q,
   input  logic             periodic,
   input  logic             masked,
   input  logic [VEC_W-1:0] vec,
   output logic [CNT_W-1:0] cur_q,
   output logic             running_q,
   output logic             irq_pulse,
   output logic [VEC_W-1:0] irq_vector
);
   logic expire;

   assign expire = tick && running_q && (cur_q == '0) && !load_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= '0;
         running_q <= 1'b0;
      end else if (load_wr) begin
         cur_q     <= load_data;
         running_q <= (load_data != '0);
      end else if (tick && running_q) begin
         if (cur_q == '0) begin
            if (periodic) cur_q <= load_q;
            else          running_q <= 1'b0;
         end else begin
            cur_q <= cur_q - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_pulse  <= 1'b0;
         irq_vector <= '0;
      end else begin
         irq_pulse <= expire && !masked;
         if (expire) irq_vector <= vec;
      end
   end
endmodule

// File: rtl/irqtmr_regs.sv
module irqtmr_regs
   import irqtmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int VEC_W  = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [CNT_W-1:0]  cur,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [VEC_W-1:0]  ctrl_vec,
   output logic              ctrl_mask,
   output logic              ctrl_per,
   output logic [CNT_W-1:0]  load_q,
   output logic              load_wr,
   output logic [IDX_W-1:0]  div_idx
);
   logic [3:0] div_q;

   if (VEC_W > CTRL_MASK_BIT) begin : g_bad_vec
      $error("vector field overlaps the mask bit");
   end
   if (CNT_W > DATA_W || DATA_W <= CTRL_PER_BIT) begin : g_bad_w
      $error("register width too small");
   end
   if (IDX_W != 3) begin : g_bad_idx
      $error("divider code carries exactly three bits");
   end

   assign load_wr = reg_wr && (reg_addr == RA_LOAD);
   assign div_idx = {div_q[3], div_q[1], div_q[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_vec  <= '0;
         ctrl_mask <= 1'b1;
         ctrl_per  <= 1'b0;
         load_q    <= '0;
         div_q     <= '0;
      end else if (reg_wr) begin
         unique case (reg_addr)
            RA_CTRL: begin
               ctrl_vec  <= reg_wdata[VEC_W-1:0];
               ctrl_mask <= reg_wdata[CTRL_MASK_BIT];
               ctrl_per  <= reg_wdata[CTRL_PER_BIT];
            end
            RA_LOAD: load_q <= reg_wdata[CNT_W-1:0];
            RA_DIV:  div_q  <= reg_wdata[3:0] & DIV_KEEP[3:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CTRL: begin
            reg_rdata[VEC_W-1:0]     = ctrl_vec;
            reg_rdata[CTRL_MASK_BIT] = ctrl_mask;
            reg_rdata[CTRL_PER_BIT]  = ctrl_per;
         end
         RA_LOAD: reg_rdata[CNT_W-1:0] = load_q;
         RA_LIVE: reg_rdata[CNT_W-1:0] = cur;
         default: reg_rdata[3:0] = div_q;
      endcase
   end
endmodule

// File: rtl/local_irq_timer.sv
module local_irq_timer #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int VEC_W  = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_pulse,
   output logic [VEC_W-1:0]  irq_vector
);
   logic [VEC_W-1:0] ctrl_vec;
   logic             ctrl_mask;
   logic             ctrl_per;
   logic [CNT_W-1:0] load_q;
   logic             load_wr;
   logic [IDX_W-1:0] div_idx;
   logic             tick;
   logic [CNT_W-1:0] cur;
   logic             running;

   irqtmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .cur(cur), .reg_rdata(reg_rdata),
      .ctrl_vec(ctrl_vec), .ctrl_mask(ctrl_mask), .ctrl_per(ctrl_per),
      .load_q(load_q), .load_wr(load_wr), .div_idx(div_idx)
   );

   irqtmr_prescaler #(.IDX_W(IDX_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(load_wr), .div_idx(div_idx), .tick(tick)
   );

   irqtmr_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load_wr(load_wr),
      .load_data(reg_wdata[CNT_W-1:0]), .load_q(load_q), .periodic(ctrl_per),
      .masked(ctrl_mask), .vec(ctrl_vec), .cur_q(cur), .running_q(running),
      .irq_pulse(irq_pulse), .irq_vector(irq_vector)
   );
endmodule

// File: rtl/local_irq_timer_chk.sv
module local_irq_timer_chk #(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_pulse,
   input logic [VEC_W-1:0] irq_vector,
   input logic             tick,
   input logic             load_wr,
   input logic [CNT_W-1:0] cur,
   input logic             running,
   input logic             ctrl_mask,
   input logic [VEC_W-1:0] ctrl_vec,
   input logic [CNT_W-1:0] load_q
);
   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse); // R10
   AST_VECTOR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> irq_vector == $past(ctrl_vec)); // R10
   AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> !$past(ctrl_mask)); // R9
   AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_wr && !tick) |=> $stable(cur)); // R5
   AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && cur == '0 && !load_wr) |=> cur == '0); // R6
   AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(load_q) != '0); // R8
endmodule

bind local_irq_timer local_irq_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .irq_vector(irq_vector),
   .tick(tick), .load_wr(load_wr), .cur(cur), .running(running),
   .ctrl_mask(ctrl_mask), .ctrl_vec(ctrl_vec), .load_q(load_q)
);

// File: tb/sim_local_irq_timer.sv
module sim_local_irq_timer;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      int         cyc;
      logic [7:0] vec;
      string      tag;
   } exp_item_t;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        reg_wr = 0;
   logic [1:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        irq_pulse;
   logic [7:0]  irq_vector;

   int checks = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 0;
   exp_item_t sb[$];

   local_irq_timer u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_pulse(irq_pulse), .irq_vector(irq_vector)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // write on the next edge; returns the bench cycle number of that edge
   task automatic wr(logic [1:0] a, logic [31:0] d, output int edge_cyc);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      reg_wr = 0;
      edge_cyc = cyc;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic expect_at(int c, logic [7:0] v, string tag);
      exp_item_t it;
      it.cyc = c; it.vec = v; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
      idle(4);
   endtask

   // monitor: compares each pulse with the front of the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (sb.size() != 0 && cyc > sb[0].cyc) begin
            checks++; bad++;
            $display("FAIL %s missed pulse actual=none expected=cycle %0d", sb[0].tag, sb[0].cyc);
            void'(sb.pop_front());
         end
         if (irq_pulse) begin
            if (sb.size() == 0) begin
               checks++; bad++;
               $display("FAIL R6/R8/R9 unexpected pulse actual=cycle %0d expected=none", cyc);
            end else begin
               exp_item_t it;
               it = sb.pop_front();
               check({it.tag, " pulse cycle"}, 32'(cyc), 32'(it.cyc));
               check({it.tag, " vector"}, 32'(irq_vector), 32'(it.vec));
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         bad++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int c0, e, j;

      idle(3);
      // R1 reset state
      rd(2'd0, v); check("R1 ctrl", v, 32'h0001_0000);
      rd(2'd1, v); check("R1 load", v, 0);
      rd(2'd2, v); check("R1 live", v, 0);
      rd(2'd3, v); check("R1 div", v, 0);
      check("R1 pulse", 32'(irq_pulse), 0);
      rst_n = 1;
      idle(2);

      // R2 control fields, R3 divider kept bits
      wr(2'd0, 32'hFFFF_FFFF, e);
      rd(2'd0, v); check("R2 ctrl fields", v, 32'h0003_00FF);
      wr(2'd3, 32'hFFFF_FFFF, e);
      rd(2'd3, v); check("R3 div keep", v, 32'h0000_000B);
      wr(2'd3, 32'h0000_00F4, e);
      rd(2'd3, v); check("R3 div drop", v, 32'h0);

      // R6 one-shot, divide by 1 (index 7)
      wr(2'd0, 32'h0000_0041, e);
      wr(2'd3, 32'h0000_000B, e);
      wr(2'd1, 32'd5, c0);
      expect_at(c0 + 6, 8'h41, "R6");
      idle(30);
      rd(2'd2, v); check("R6 holds zero", v, 0);

      // R11 live count, divide by 2 (index 0)
      wr(2'd3, 32'h0, e);
      wr(2'd1, 32'd10, c0);
      expect_at(c0 + 22, 8'h41, "R11");
      while (cyc < c0 + 7) @(negedge clk);
      reg_addr = 2'd2; #1;
      check("R11 live", reg_rdata, 32'd7);
      wr(2'd2, 32'h55, e);
      rd(2'd2, v); check("R11 write ignored", v, 32'(10 - (cyc - c0) / 2));
      drain();

      // R5 restart mid-count
      wr(2'd3, 32'h0000_000B, e);
      wr(2'd1, 32'd20, c0);
      idle(5);
      wr(2'd1, 32'd4, e);
      expect_at(e + 5, 8'h41, "R5");
      idle(40);
      drain();

      // R7 periodic, divide by 4 (index 1): period 16
      wr(2'd0, 32'h0002_0077, e);
      wr(2'd3, 32'h1, e);
      wr(2'd1, 32'd3, c0);
      for (int k = 1; k <= 3; k++) expect_at(c0 + 16 * k, 8'h77, "R7");
      while (cyc < c0 + 50) @(negedge clk);
      // R9 mask across two expiries
      wr(2'd0, 32'h0003_0077, e);
      idle(40);
      // R12 unmask keeps the period grid
      wr(2'd0, 32'h0002_0077, e);
      j = (e - c0) / 16 + 1;
      expect_at(c0 + 16 * j, 8'h77, "R12");
      drain();
      // R8 zero load stops periodic
      wr(2'd1, 32'd0, e);
      idle(60);
      rd(2'd2, v); check("R8 live zero", v, 0);

      // R8 zero load in one-shot
      wr(2'd0, 32'h0000_0033, e);
      wr(2'd3, 32'h0000_000B, e);
      wr(2'd1, 32'd0, e);
      idle(20);

      // R4 divide by 16 (index 3) and by 32 (index 4)
      wr(2'd3, 32'h3, e);
      wr(2'd1, 32'd2, c0);
      expect_at(c0 + 48, 8'h33, "R4 div16");
      drain();
      wr(2'd3, 32'h8, e);
      wr(2'd1, 32'd1, c0);
      expect_at(c0 + 64, 8'h33, "R4 div32");
      drain();

      // R10 one-cycle pulse with vector from control
      wr(2'd0, 32'h0000_00A5, e);
      wr(2'd3, 32'h0000_000B, e);
      wr(2'd1, 32'd3, c0);
      expect_at(c0 + 4, 8'hA5, "R10");
      while (cyc < c0 + 5) @(negedge clk);
      check("R10 pulse drops", 32'(irq_pulse), 0);
      drain();

      if (sb.size() != 0) begin
         checks++; bad++;
         $display("FAIL scoreboard actual=%0d left expected=0", sb.size());
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule